// File: doc/BRIEF.md
# Register Readiness Scoreboard with Operand Wakeup and Flush

This block keeps track of which physical registers hold a valid value and which waiting instructions still need a value that has not been produced. Each physical register has one ready bit. Each instruction-queue slot holds up to two source tags, and each source has its own pending flag. When an instruction is allocated into a slot, its destination register is marked not ready. Any source whose register is not ready at that moment is recorded as pending. A completion broadcast then sets the ready bit of the produced register and clears every pending source that carries that tag. A slot with no pending source raises its ready line toward the issue logic.

Waiters are not kept as linked lists. Each slot compares its stored source tags against the broadcast tag. A register index at or above the number of tracked registers is ignored on every path. It never becomes a producer, it never makes a source pending, and broadcasting it changes nothing. Instructions that must wait for an explicit go-ahead (serialising operations, stores) are allocated as no-wait slots. Such a slot never records a pending source and stays not-ready until a release names it. A flush drops every occupied slot whose sequence number is strictly larger than the flush sequence number. Issue frees a ready slot. The reset input is asynchronous and active low, and it is expected to be released synchronously to the clock.

Top module: `wakeup_scoreboard`

## Requirements
- R1: During and right after reset, every bit of `reg_ready` is 1, and every bit of `slot_busy` and `slot_ready` is 0.
- R2: An allocation with `alloc_dst_en` set and `alloc_dst` below NUM_PREGS clears `reg_ready[alloc_dst]` on the next clock edge. A destination index at or above NUM_PREGS leaves `reg_ready` unchanged. An allocation must not name a destination on which an occupied slot still has a pending source.
- R3: At allocation, source k (bit k of `alloc_src_en`; bit 0 is `alloc_src0`, bit 1 is `alloc_src1`) becomes pending only when all of these hold:
  - the source is enabled;
  - the slot is not no-wait;
  - its tag is below NUM_PREGS;
  - its `reg_ready` bit is 0.
- R4: A completion with `cmpl_tag` below NUM_PREGS sets `reg_ready[cmpl_tag]` on the next edge. If an allocation clears the same register in the same cycle, the clear wins. A completion tag at or above NUM_PREGS changes no `reg_ready` bit and no slot.
- R5: A completion clears, on the next edge, every pending source in every occupied slot whose stored tag equals `cmpl_tag`. A slot whose last pending source clears shows `slot_ready` one cycle after the completion cycle.
- R6: `slot_ready[i]` is 1 exactly when all three hold:
  - slot i is occupied;
  - it has no pending source;
  - it is a normal slot, or a no-wait slot that has been released.
- R7: A no-wait slot (`alloc_no_wait`=1) keeps `slot_ready` at 0 until `release_valid` names it. A release that names a normal slot has no effect.
- R8: A flush clears `slot_busy` on the next edge for every occupied slot whose sequence number is greater than `flush_seq` (unsigned compare). Slots with an equal or smaller sequence number stay. A flush leaves `reg_ready` unchanged, and a later completion does not revive a dropped slot.
- R9: Issue of a ready slot clears its `slot_busy` and `slot_ready` on the next edge, and the slot may then be allocated again. Allocation targets only a free slot.
- R10: If a source tag equals `cmpl_tag` while a completion is valid in the allocation cycle, that source is not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate an instruction into a slot this cycle |
| alloc_slot | input | SLOT_W | Target slot index |
| alloc_seq | input | SEQ_W | Sequence number of the instruction |
| alloc_no_wait | input | 1 | Slot waits for an explicit release instead of operands |
| alloc_dst_en | input | 1 | The instruction writes a destination register |
| alloc_dst | input | TAG_W | Destination register index |
| alloc_src_en | input | 2 | Per-source enable, bit 0 for source 0 |
| alloc_src0 | input | TAG_W | Source 0 register index |
| alloc_src1 | input | TAG_W | Source 1 register index |
| cmpl_valid | input | 1 | Completion broadcast valid |
| cmpl_tag | input | TAG_W | Register produced by the completion |
| flush_valid | input | 1 | Drop slots younger than flush_seq |
| flush_seq | input | SEQ_W | Flush boundary sequence number |
| release_valid | input | 1 | Release a no-wait slot |
| release_slot | input | SLOT_W | Slot to release |
| issue_valid | input | 1 | A ready slot issues and is freed |
| issue_slot | input | SLOT_W | Slot that issues |
| slot_busy | output | SLOTS | Bit i: slot i occupied |
| slot_ready | output | SLOTS | Bit i: slot i may issue |
| reg_ready | output | NUM_PREGS | Bit i: register i holds a valid value |

## Verification
A lost wakeup leaves a slot's `slot_ready` low forever, one cycle after the completion that should have raised it. That makes a stalled consumer visible on the very next sample. A spurious wakeup, or a wrong insertion-time decision, shows the reverse: `slot_ready` is high while a producer is still outstanding. A mis-indexed ready bit shows up in `reg_ready` one edge after the allocation or completion that touched it. A flush that compares the wrong way, or misses the equal case, shows up in `slot_busy` on the edge after the flush. The directed sequences hit these cases: bypass indices, no-wait release, same-cycle completion with allocation on both the source and the destination side, and flush boundaries.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // number of source operands held per queue slot
  localparam int unsigned SRC_N = 2;
  typedef logic [SRC_N-1:0] src_mask_t;
endpackage

// File: rtl/wsb_ready_bits.sv
module wsb_ready_bits #(
  parameter int unsigned NUM_PREGS = 16,
  parameter int unsigned TAG_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [TAG_W-1:0]     set_tag,
  input  logic                 clr_en,
  input  logic [TAG_W-1:0]     clr_tag,
  output logic [NUM_PREGS-1:0] ready_o
);
  logic [NUM_PREGS-1:0] rdy_q, rdy_d, set_oh, clr_oh;
  logic                 upd_en;

  // one-hot decode; indices outside the tracked range decode to nothing
  always_comb begin
    set_oh = '0;
    clr_oh = '0;
    for (int i = 0; i < NUM_PREGS; i++) begin
      set_oh[i] = set_en && (set_tag == TAG_W'(i));
      clr_oh[i] = clr_en && (clr_tag == TAG_W'(i));
    end
  end

  // a new producer wins over a completion to the same register
  always_comb begin
    rdy_d  = (rdy_q | set_oh) & ~clr_oh;
    upd_en = (|set_oh) | (|clr_oh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '1;
    else if (upd_en) rdy_q <= rdy_d;
  end

  assign ready_o = rdy_q;

  p_cmpl_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ready_o & $past(set_oh & ~clr_oh)) == $past(set_oh & ~clr_oh)));
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ready_o & $past(clr_oh)) == '0));
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_oh == '0 && clr_oh == '0) |=> $stable(ready_o));
endmodule

// File: rtl/wsb_slot.sv
module wsb_slot
  import wsb_pkg::*;
#(
  parameter int unsigned TAG_W = 5,
  parameter int unsigned SEQ_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic [SEQ_W-1:0]            ld_seq,
  input  logic                        ld_no_wait,
  input  src_mask_t                   ld_pend,
  input  logic [SRC_N-1:0][TAG_W-1:0] ld_tag,
  input  logic                        wake_v,
  input  logic [TAG_W-1:0]            wake_tag,
  input  logic                        kill_v,
  input  logic [SEQ_W-1:0]            kill_seq,
  input  logic                        rel,
  input  logic                        iss,
  input  logic [TAG_W-1:0]            probe_tag,
  output logic                        busy_o,
  output logic                        ready_o,
  output logic                        waits_o
);
  logic                        busy_q, busy_d, nw_q, nw_d, rel_q, rel_d;
  src_mask_t                   pend_q, pend_d, hit;
  logic [SEQ_W-1:0]            seq_q;
  logic [SRC_N-1:0][TAG_W-1:0] tag_q;
  logic                        drop, st_en, younger;

  always_comb begin
    for (int k = 0; k < SRC_N; k++) hit[k] = wake_v && (tag_q[k] == wake_tag);
    younger = seq_q > kill_seq;
    drop    = busy_q && (iss || (kill_v && younger));
    busy_d  = busy_q;
    pend_d  = pend_q;
    rel_d   = rel_q;
    nw_d    = nw_q;
    if (ld) begin
      busy_d = 1'b1;
      pend_d = ld_pend;
      rel_d  = 1'b0;
      nw_d   = ld_no_wait;
    end else if (drop) begin
      busy_d = 1'b0;
      pend_d = '0;
      rel_d  = 1'b0;
    end else if (busy_q) begin
      pend_d = pend_q & ~hit;
      if (rel) rel_d = 1'b1;
    end
    st_en = ld | busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      rel_q  <= 1'b0;
      nw_q   <= 1'b0;
    end else if (st_en) begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      rel_q  <= rel_d;
      nw_q   <= nw_d;
    end
  end

  // payload needs no reset: it is only observed while busy_q is set
  always_ff @(posedge clk) begin
    if (ld) begin
      seq_q <= ld_seq;
      tag_q <= ld_tag;
    end
  end

  always_comb begin
    waits_o = 1'b0;
    for (int k = 0; k < SRC_N; k++)
      if (busy_q && pend_q[k] && (tag_q[k] == probe_tag)) waits_o = 1'b1;
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (pend_q == '0) && (!nw_q || rel_q);

  p_wake_src0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ld && !drop && pend_q[0] && wake_v && tag_q[0] == wake_tag) |=> !pend_q[0]);
  p_wake_src1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ld && !drop && pend_q[1] && wake_v && tag_q[1] == wake_tag) |=> !pend_q[1]);
  p_flush_young_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ld && kill_v && younger) |=> !busy_o);
  p_flush_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ld && !iss && kill_v && !younger) |=> busy_o);
  p_nowait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_no_wait) |=> !ready_o);
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_PREGS = 16,
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned SEQ_W     = 6,
  localparam int unsigned SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [SLOT_W-1:0]    alloc_slot,
  input  logic [SEQ_W-1:0]     alloc_seq,
  input  logic                 alloc_no_wait,
  input  logic                 alloc_dst_en,
  input  logic [TAG_W-1:0]     alloc_dst,
  input  logic [1:0]           alloc_src_en,
  input  logic [TAG_W-1:0]     alloc_src0,
  input  logic [TAG_W-1:0]     alloc_src1,
  input  logic                 cmpl_valid,
  input  logic [TAG_W-1:0]     cmpl_tag,
  input  logic                 flush_valid,
  input  logic [SEQ_W-1:0]     flush_seq,
  input  logic                 release_valid,
  input  logic [SLOT_W-1:0]    release_slot,
  input  logic                 issue_valid,
  input  logic [SLOT_W-1:0]    issue_slot,
  output logic [SLOTS-1:0]     slot_busy,
  output logic [SLOTS-1:0]     slot_ready,
  output logic [NUM_PREGS-1:0] reg_ready
);
  logic [SRC_N-1:0][TAG_W-1:0] src_tag;
  src_mask_t                   src_sb_rdy, ins_pend;
  logic [SLOTS-1:0]            slot_waits;

  assign src_tag = {alloc_src1, alloc_src0};

  wsb_ready_bits #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (cmpl_valid),
    .set_tag (cmpl_tag),
    .clr_en  (alloc_valid && alloc_dst_en),
    .clr_tag (alloc_dst),
    .ready_o (reg_ready)
  );

  // insertion-time readiness: untracked indices look ready, and a value
  // completing in the same cycle counts as already present
  always_comb begin
    for (int k = 0; k < SRC_N; k++) begin
      src_sb_rdy[k] = 1'b1;
      for (int i = 0; i < NUM_PREGS; i++)
        if (src_tag[k] == TAG_W'(i)) src_sb_rdy[k] = reg_ready[i];
      ins_pend[k] = alloc_src_en[k] && !alloc_no_wait && !src_sb_rdy[k] &&
                    !(cmpl_valid && (cmpl_tag == src_tag[k]));
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    wsb_slot #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld         (alloc_valid && (alloc_slot == SLOT_W'(g))),
      .ld_seq     (alloc_seq),
      .ld_no_wait (alloc_no_wait),
      .ld_pend    (ins_pend),
      .ld_tag     (src_tag),
      .wake_v     (cmpl_valid),
      .wake_tag   (cmpl_tag),
      .kill_v     (flush_valid),
      .kill_seq   (flush_seq),
      .rel        (release_valid && (release_slot == SLOT_W'(g))),
      .iss        (issue_valid && (issue_slot == SLOT_W'(g))),
      .probe_tag  (alloc_dst),
      .busy_o     (slot_busy[g]),
      .ready_o    (slot_ready[g]),
      .waits_o    (slot_waits[g])
    );
  end

  p_alloc_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !slot_busy[alloc_slot]);
  p_issue_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> slot_ready[issue_slot]);
  p_no_live_waiters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_dst_en) |-> (slot_waits == '0));
  p_same_cycle_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_no_wait && cmpl_valid &&
     (!alloc_src_en[0] || alloc_src0 == cmpl_tag) &&
     (!alloc_src_en[1] || alloc_src1 == cmpl_tag)) |=> slot_ready[$past(alloc_slot)]);
endmodule

// File: tb/wakeup_scoreboard_bench.sv
`timescale 1ns/1ps
module wakeup_scoreboard_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic       alloc_valid, alloc_no_wait, alloc_dst_en;
  logic [1:0] alloc_slot, alloc_src_en;
  logic [5:0] alloc_seq;
  logic [4:0] alloc_dst, alloc_src0, alloc_src1;
  logic       cmpl_valid, flush_valid, release_valid, issue_valid;
  logic [4:0] cmpl_tag;
  logic [5:0] flush_seq;
  logic [1:0] release_slot, issue_slot;
  logic [3:0]  slot_busy, slot_ready;
  logic [15:0] reg_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wakeup_scoreboard u_wakeup_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_seq(alloc_seq),
    .alloc_no_wait(alloc_no_wait), .alloc_dst_en(alloc_dst_en), .alloc_dst(alloc_dst),
    .alloc_src_en(alloc_src_en), .alloc_src0(alloc_src0), .alloc_src1(alloc_src1),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .flush_valid(flush_valid), .flush_seq(flush_seq),
    .release_valid(release_valid), .release_slot(release_slot),
    .issue_valid(issue_valid), .issue_slot(issue_slot),
    .slot_busy(slot_busy), .slot_ready(slot_ready), .reg_ready(reg_ready)
  );

  typedef struct packed {
    logic av; logic [1:0] aslot; logic [5:0] aseq; logic anw; logic aden;
    logic [4:0] adst; logic [1:0] asen; logic [4:0] as0; logic [4:0] as1;
    logic cv; logic [4:0] ctag; logic fv; logic [5:0] fseq;
    logic rv; logic [1:0] rslot; logic iv; logic [1:0] islot;
    logic [3:0] ebusy; logic [3:0] erdy; logic [15:0] ereg;
  } vec_t;

  function automatic vec_t mk(int av, int aslot, int aseq, int anw, int aden, int adst,
                              int asen, int as0, int as1, int cv, int ctag, int fv, int fseq,
                              int rv, int rslot, int iv, int islot,
                              int ebusy, int erdy, int ereg);
    vec_t v;
    v.av = av[0]; v.aslot = aslot[1:0]; v.aseq = aseq[5:0]; v.anw = anw[0];
    v.aden = aden[0]; v.adst = adst[4:0]; v.asen = asen[1:0];
    v.as0 = as0[4:0]; v.as1 = as1[4:0]; v.cv = cv[0]; v.ctag = ctag[4:0];
    v.fv = fv[0]; v.fseq = fseq[5:0]; v.rv = rv[0]; v.rslot = rslot[1:0];
    v.iv = iv[0]; v.islot = islot[1:0];
    v.ebusy = ebusy[3:0]; v.erdy = erdy[3:0]; v.ereg = ereg[15:0];
    return v;
  endfunction

  localparam int NV = 16;
  // av sl seq nw de dst se s0 s1 | cv tag | fv fseq | rv rs | iv is || busy rdy reg
  localparam vec_t TBL [NV] = '{
    mk(1,0,10,0,1, 3,0,0,0, 0, 0, 0, 0, 0,0, 0,0, 4'b0001,4'b0001,16'hFFF7), // R2 no sources
    mk(1,1,11,0,1, 4,1,3,0, 0, 0, 0, 0, 0,0, 0,0, 4'b0011,4'b0001,16'hFFE7), // R3 src 3 pending
    mk(1,2,12,0,1, 5,3,3,4, 1, 4, 0, 0, 0,0, 1,0, 4'b0110,4'b0000,16'hFFD7), // R10 src 4 completes now
    mk(0,0, 0,0,0, 0,0,0,0, 1, 3, 0, 0, 0,0, 0,0, 4'b0110,4'b0110,16'hFFDF), // R5 wake two slots
    mk(1,0,13,1,1,20,3,5,5, 0, 0, 0, 0, 0,0, 0,0, 4'b0111,4'b0110,16'hFFDF), // R7 no-wait, bypass dst
    mk(0,0, 0,0,0, 0,0,0,0, 1,25, 0, 0, 1,1, 0,0, 4'b0111,4'b0110,16'hFFDF), // R7 release normal, bypass cmpl
    mk(0,0, 0,0,0, 0,0,0,0, 0, 0, 0, 0, 1,0, 1,1, 4'b0101,4'b0101,16'hFFDF), // R6 release + R9 issue
    mk(1,1,14,0,1, 6,1,5,0, 0, 0, 0, 0, 0,0, 0,0, 4'b0111,4'b0101,16'hFF9F), // R3 reuse slot, src pending
    mk(1,3,15,0,1, 7,2,0,6, 0, 0, 0, 0, 0,0, 0,0, 4'b1111,4'b0101,16'hFF1F), // R3 src1 only
    mk(0,0, 0,0,0, 0,0,0,0, 0, 0, 1,14, 0,0, 0,0, 4'b0111,4'b0101,16'hFF1F), // R8 drop seq 15 only
    mk(0,0, 0,0,0, 0,0,0,0, 1, 6, 0, 0, 0,0, 0,0, 4'b0111,4'b0101,16'hFF5F), // R4 no revive
    mk(1,3,16,0,1, 8,1,7,0, 1, 5, 0, 0, 0,0, 0,0, 4'b1111,4'b0111,16'hFE7F), // R5 wake while alloc
    mk(0,0, 0,0,0, 0,0,0,0, 1, 7, 0, 0, 0,0, 1,2, 4'b1011,4'b1011,16'hFEFF), // R9 issue + wake
    mk(0,0, 0,0,0, 0,0,0,0, 0, 0, 1,13, 0,0, 0,0, 4'b0001,4'b0001,16'hFEFF), // R8 two dropped
    mk(1,1,17,0,1, 9,0,0,0, 1, 9, 0, 0, 0,0, 0,0, 4'b0011,4'b0011,16'hFCFF), // R4 clear wins
    mk(0,0, 0,0,0, 0,0,0,0, 1, 9, 1,17, 0,0, 0,0, 4'b0011,4'b0011,16'hFEFF)  // R8 equal kept
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R10"; 3: return "R5";
      4: return "R7";  5: return "R7/R4"; 6: return "R6/R9"; 7: return "R3";
      8: return "R3";  9: return "R8";  10: return "R4"; 11: return "R5";
      12: return "R9"; 13: return "R8"; 14: return "R4"; default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_slot = 0; alloc_seq = 0; alloc_no_wait = 0;
    alloc_dst_en = 0; alloc_dst = 0; alloc_src_en = 0; alloc_src0 = 0; alloc_src1 = 0;
    cmpl_valid = 0; cmpl_tag = 0; flush_valid = 0; flush_seq = 0;
    release_valid = 0; release_slot = 0; issue_valid = 0; issue_slot = 0;
  endtask

  task automatic apply(vec_t v);
    alloc_valid = v.av; alloc_slot = v.aslot; alloc_seq = v.aseq; alloc_no_wait = v.anw;
    alloc_dst_en = v.aden; alloc_dst = v.adst; alloc_src_en = v.asen;
    alloc_src0 = v.as0; alloc_src1 = v.as1; cmpl_valid = v.cv; cmpl_tag = v.ctag;
    flush_valid = v.fv; flush_seq = v.fseq; release_valid = v.rv; release_slot = v.rslot;
    issue_valid = v.iv; issue_slot = v.islot;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "reg_ready in reset", 32'(reg_ready), 32'hFFFF);
    chk("R1", "slot_busy in reset", 32'(slot_busy), 32'h0);
    chk("R1", "slot_ready in reset", 32'(slot_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reg_ready after release", 32'(reg_ready), 32'hFFFF);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      chk(req_of(i), $sformatf("row %0d slot_busy", i), 32'(slot_busy), 32'(TBL[i].ebusy));
      chk(req_of(i), $sformatf("row %0d slot_ready", i), 32'(slot_ready), 32'(TBL[i].erdy));
      chk(req_of(i), $sformatf("row %0d reg_ready", i), 32'(reg_ready), 32'(TBL[i].ereg));
    end
    idle();

    // R3: untracked source and a source whose bit is set are not pending
    alloc_valid = 1; alloc_slot = 2; alloc_seq = 20; alloc_dst_en = 1; alloc_dst = 10;
    alloc_src_en = 2'b11; alloc_src0 = 18; alloc_src1 = 9;
    @(negedge clk);
    idle();
    chk("R3", "bypass source slot_ready[2]", 32'(slot_ready[2]), 32'h1);
    chk("R2", "dst 10 cleared", 32'(reg_ready[10]), 32'h0);

    // R7: no-wait slot stays not ready without release
    alloc_valid = 1; alloc_slot = 3; alloc_seq = 21; alloc_no_wait = 1;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R7", "no-wait slot_ready[3] held low", 32'(slot_ready[3]), 32'h0);
    release_valid = 1; release_slot = 3;
    @(negedge clk);
    idle();
    chk("R7", "released slot_ready[3]", 32'(slot_ready[3]), 32'h1);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1", "reg_ready on async reset", 32'(reg_ready), 32'hFFFF);
    chk("R1", "slot_busy on async reset", 32'(slot_busy), 32'h0);
    chk("R1", "slot_ready on async reset", 32'(slot_ready), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule